// File: doc/BRIEF.md
# Machine Check Error Bank Logger

This block keeps a set of machine-check error banks and decides, for every injected hardware error, whether it is recorded, masked, refused or escalated. Each bank holds four 64-bit words: a per-bank enable mask (control), an error status, an error address and an auxiliary (misc) word. Three global words sit beside the banks. The capability word gives the usable bank count in bits [7:0] and a "global control present" flag in bit 8. The global control word is the global enable mask. The global status word carries the "check in progress" flag in bit 2.

An injection request carries a bank index, a status word, a global-status word, an address, a misc word and an unconditional flag. The request is judged against the current state in one cycle. One cycle later a 2-bit result code comes out with a single-cycle valid strobe. An interrupt pulse is raised for a recorded uncorrected error. A reset request pulse is raised when the error cannot be delivered safely. A simple write port loads any register and a registered read port returns any register, so the stored state can be observed.

Status word bit positions: valid = 63, overflow = 62, uncorrected = 61, action-required = 55.

Top module: `mcbank_logger`

## Requirements
- R1: A request is rejected (code 1) when the capability word is zero, when the bank index is not below capability bits [7:0], when the bank index is not below the NUM_BANKS parameter, or when status bit 63 (valid) is clear. A rejected request changes no register.
- R2: A request whose status has bit 55 (action-required) clear is ignored (code 2) while global status bit 2 is set, unless the unconditional flag is set. An ignored request changes no register.
- R3: An uncorrected request (status bit 61 set) is ignored (code 2) when capability bit 8 is set and the global control word is not all ones. With capability bit 8 clear, the global control word has no effect.
- R4: An uncorrected request is ignored (code 2) when the target bank's control word is not all ones.
- R5: An uncorrected request that passes R3 and R4 gives code 3 and a one-cycle reset_req pulse, with no register written, when mce_en is low or global status bit 2 is already set.
- R6: Any other uncorrected request gives code 0 and a one-cycle mce_irq pulse. It stores the address, the misc word, the request's global-status word, and the request status with bit 62 (overflow) set when the old bank status had bit 63 set.
- R7: A corrected request (bit 61 clear) aimed at a bank whose old status is invalid or corrected gives code 0. It stores the address, the misc word, and the request status with bit 62 set if the old status was valid. It raises neither pulse and leaves global status alone.
- R8: A corrected request aimed at a bank holding a valid uncorrected status gives code 0 and only sets bit 62 of the existing status. Address and misc keep their values.
- R9: res_valid is high for exactly the cycle after each request cycle, with codes 0 accept, 1 reject, 2 ignore, 3 reset. mce_irq and reset_req are never high together.
- R10: Synchronous reset clears every register to zero. A read returns the selected register on rd_data one cycle after rd_sel/rd_bank are presented (selectors 0 capability, 1 global control, 2 global status, 3 bank control, 4 bank status, 5 bank address, 6 bank misc). A bank index at or above NUM_BANKS reads as zero.
- R11: A write with wr_en stores wr_data into the register chosen by wr_sel/wr_bank, using the R10 selector codes, on the next clock edge. An injection update to the same register in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mce_en | input | 1 | Machine-check delivery enabled by the core |
| inj_valid | input | 1 | Injection request strobe |
| inj_bank | input | 8 | Target bank index |
| inj_status | input | DATA_W | Error status word |
| inj_gstatus | input | DATA_W | Global-status value stored on an uncorrected accept |
| inj_addr | input | DATA_W | Error address |
| inj_misc | input | DATA_W | Auxiliary error word |
| inj_uncond | input | 1 | Deliver action-optional error even during a check in progress |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector |
| wr_bank | input | 8 | Bank index for bank registers |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 3 | Read selector |
| rd_bank | input | 8 | Read bank index |
| rd_data | output | DATA_W | Registered read data |
| res_valid | output | 1 | Result strobe |
| res_code | output | 2 | Result code |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | Reset (triple-fault) request pulse |

## Verification
The bench builds the block with NUM_BANKS = 5 and the default 64-bit word width. Because the capability word can advertise up to 255 banks, a count of 8 lets indices 5 to 7 pass the software count while failing the hardware limit, so both halves of the bank-range rejection can be hit. Five banks are enough to hold a valid uncorrected entry, a corrected entry, a masked bank and clean banks at the same time. This makes the overflow-only path and the masking paths reachable within one sequence.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int ST_VAL    = 63;
  localparam int ST_OVER   = 62;
  localparam int ST_UC     = 61;
  localparam int ST_AR     = 55;
  localparam int GS_INPROG = 2;
  localparam int CAP_CTLP  = 8;

  typedef enum logic [1:0] {
    RES_ACCEPT = 2'd0,
    RES_REJECT = 2'd1,
    RES_IGNORE = 2'd2,
    RES_RESET  = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    SEL_CAP   = 3'd0,
    SEL_GCTL  = 3'd1,
    SEL_GSTAT = 3'd2,
    SEL_BCTL  = 3'd3,
    SEL_BSTAT = 3'd4,
    SEL_BADDR = 3'd5,
    SEL_BMISC = 3'd6
  } sel_e;
endpackage

// File: rtl/mcb_decide.sv
module mcb_decide
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 64
) (
  input  logic [DATA_W-1:0] cap,
  input  logic [DATA_W-1:0] gctl,
  input  logic [DATA_W-1:0] gstat,
  input  logic              mce_en,
  input  logic [DATA_W-1:0] bank_ctl,
  input  logic [DATA_W-1:0] old_status,
  input  logic [7:0]        req_bank,
  input  logic [DATA_W-1:0] req_status,
  input  logic              req_uncond,
  output logic [1:0]        code,
  output logic              we_info,
  output logic              we_stat,
  output logic              we_gstat,
  output logic [DATA_W-1:0] new_status,
  output logic              raise_irq,
  output logic              raise_rst
);
  localparam logic [7:0]        NB8  = 8'(NUM_BANKS);
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  logic in_range, recursive, ar, uc, old_val, old_uc;

  always_comb begin
    in_range  = (cap != '0) && (req_bank < cap[7:0]) && (req_bank < NB8)
                && req_status[ST_VAL];
    recursive = gstat[GS_INPROG];
    ar        = req_status[ST_AR];
    uc        = req_status[ST_UC];
    old_val   = old_status[ST_VAL];
    old_uc    = old_status[ST_UC];

    code       = RES_ACCEPT;
    we_info    = 1'b0;
    we_stat    = 1'b0;
    we_gstat   = 1'b0;
    raise_irq  = 1'b0;
    raise_rst  = 1'b0;
    new_status = req_status;
    if (old_val) new_status[ST_OVER] = 1'b1;

    if (!in_range) begin
      code = RES_REJECT;
    end else if (!req_uncond && !ar && recursive) begin
      code = RES_IGNORE;
    end else if (uc) begin
      if (cap[CAP_CTLP] && (gctl != ONES)) begin
        code = RES_IGNORE;
      end else if (bank_ctl != ONES) begin
        code = RES_IGNORE;
      end else if (!mce_en || recursive) begin
        code      = RES_RESET;
        raise_rst = 1'b1;
      end else begin
        we_info   = 1'b1;
        we_stat   = 1'b1;
        we_gstat  = 1'b1;
        raise_irq = 1'b1;
      end
    end else if (!old_val || !old_uc) begin
      we_info = 1'b1;
      we_stat = 1'b1;
    end else begin
      we_stat                = 1'b1;
      new_status             = old_status;
      new_status[ST_OVER]    = 1'b1;
    end
  end
endmodule

// File: rtl/mcb_bank_file.sv
module mcb_bank_file
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [2:0]        sw_sel,
  input  logic [7:0]        sw_bank,
  input  logic [DATA_W-1:0] sw_data,
  input  logic              up_we_stat,
  input  logic              up_we_info,
  input  logic [7:0]        up_bank,
  input  logic [DATA_W-1:0] up_status,
  input  logic [DATA_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_misc,
  output logic [DATA_W-1:0] lk_ctl,
  output logic [DATA_W-1:0] lk_status,
  input  logic [7:0]        rd_bank,
  output logic [DATA_W-1:0] rd_ctl,
  output logic [DATA_W-1:0] rd_status,
  output logic [DATA_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_misc
);
  logic [DATA_W-1:0] ctl_q  [NUM_BANKS];
  logic [DATA_W-1:0] stat_q [NUM_BANKS];
  logic [DATA_W-1:0] addr_q [NUM_BANKS];
  logic [DATA_W-1:0] misc_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sw_hit, up_hit;
    assign sw_hit = sw_we && (sw_bank == 8'(g));
    assign up_hit = (up_bank == 8'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q[g]  <= '0;
        stat_q[g] <= '0;
        addr_q[g] <= '0;
        misc_q[g] <= '0;
      end else begin
        if (sw_hit) begin
          case (sw_sel)
            SEL_BCTL:  ctl_q[g]  <= sw_data;
            SEL_BSTAT: stat_q[g] <= sw_data;
            SEL_BADDR: addr_q[g] <= sw_data;
            SEL_BMISC: misc_q[g] <= sw_data;
            default: ;
          endcase
        end
        if (up_hit && up_we_stat) stat_q[g] <= up_status;
        if (up_hit && up_we_info) begin
          addr_q[g] <= up_addr;
          misc_q[g] <= up_misc;
        end
      end
    end
  end

  always_comb begin
    lk_ctl    = '0;
    lk_status = '0;
    rd_ctl    = '0;
    rd_status = '0;
    rd_addr   = '0;
    rd_misc   = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (up_bank == 8'(i)) begin
        lk_ctl    = ctl_q[i];
        lk_status = stat_q[i];
      end
      if (rd_bank == 8'(i)) begin
        rd_ctl    = ctl_q[i];
        rd_status = stat_q[i];
        rd_addr   = addr_q[i];
        rd_misc   = misc_q[i];
      end
    end
  end
endmodule

// File: rtl/mcbank_logger.sv
module mcbank_logger
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mce_en,
  input  logic              inj_valid,
  input  logic [7:0]        inj_bank,
  input  logic [DATA_W-1:0] inj_status,
  input  logic [DATA_W-1:0] inj_gstatus,
  input  logic [DATA_W-1:0] inj_addr,
  input  logic [DATA_W-1:0] inj_misc,
  input  logic              inj_uncond,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [7:0]        wr_bank,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_sel,
  input  logic [7:0]        rd_bank,
  output logic [DATA_W-1:0] rd_data,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic              mce_irq,
  output logic              reset_req
);
  logic [DATA_W-1:0] cap_q, gctl_q, gstat_q;
  logic [DATA_W-1:0] lk_ctl, lk_status;
  logic [DATA_W-1:0] b_ctl, b_status, b_addr, b_misc;
  logic [1:0]        d_code;
  logic              d_we_info, d_we_stat, d_we_gstat, d_irq, d_rst;
  logic [DATA_W-1:0] d_status;

  mcb_decide #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) u_decide (
    .cap(cap_q), .gctl(gctl_q), .gstat(gstat_q), .mce_en(mce_en),
    .bank_ctl(lk_ctl), .old_status(lk_status),
    .req_bank(inj_bank), .req_status(inj_status), .req_uncond(inj_uncond),
    .code(d_code), .we_info(d_we_info), .we_stat(d_we_stat),
    .we_gstat(d_we_gstat), .new_status(d_status),
    .raise_irq(d_irq), .raise_rst(d_rst)
  );

  mcb_bank_file #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) u_banks (
    .clk(clk), .rst(rst),
    .sw_we(wr_en), .sw_sel(wr_sel), .sw_bank(wr_bank), .sw_data(wr_data),
    .up_we_stat(inj_valid && d_we_stat), .up_we_info(inj_valid && d_we_info),
    .up_bank(inj_bank), .up_status(d_status),
    .up_addr(inj_addr), .up_misc(inj_misc),
    .lk_ctl(lk_ctl), .lk_status(lk_status),
    .rd_bank(rd_bank), .rd_ctl(b_ctl), .rd_status(b_status),
    .rd_addr(b_addr), .rd_misc(b_misc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q     <= '0;
      gctl_q    <= '0;
      gstat_q   <= '0;
      res_valid <= 1'b0;
      res_code  <= RES_ACCEPT;
      mce_irq   <= 1'b0;
      reset_req <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_CAP:   cap_q   <= wr_data;
          SEL_GCTL:  gctl_q  <= wr_data;
          SEL_GSTAT: gstat_q <= wr_data;
          default: ;
        endcase
      end
      if (inj_valid && d_we_gstat) gstat_q <= inj_gstatus;

      res_valid <= inj_valid;
      res_code  <= inj_valid ? d_code : RES_ACCEPT;
      mce_irq   <= inj_valid && d_irq;
      reset_req <= inj_valid && d_rst;

      case (rd_sel)
        SEL_CAP:   rd_data <= cap_q;
        SEL_GCTL:  rd_data <= gctl_q;
        SEL_GSTAT: rd_data <= gstat_q;
        SEL_BCTL:  rd_data <= b_ctl;
        SEL_BSTAT: rd_data <= b_status;
        SEL_BADDR: rd_data <= b_addr;
        SEL_BMISC: rd_data <= b_misc;
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mcb_checker.sv
module mcb_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              inj_valid,
  input logic [DATA_W-1:0] inj_status,
  input logic              res_valid,
  input logic [1:0]        res_code,
  input logic              mce_irq,
  input logic              reset_req
);
  a_r9_result_follows: assert property (@(posedge clk) disable iff (rst)
    inj_valid |=> res_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !inj_valid |=> !res_valid);
  a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mce_irq, reset_req}));
  a_r1_invalid_rejected: assert property (@(posedge clk) disable iff (rst)
    (inj_valid && !inj_status[63]) |=> (res_code == 2'd1));
  a_r6_irq_is_accept: assert property (@(posedge clk) disable iff (rst)
    mce_irq |-> (res_valid && res_code == 2'd0));
  a_r5_reset_code: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (res_valid && res_code == 2'd3));
  a_r7_corrected_quiet: assert property (@(posedge clk) disable iff (rst)
    (inj_valid && !inj_status[61]) |=> (!mce_irq && !reset_req));
endmodule

bind mcbank_logger mcb_checker #(.DATA_W(DATA_W)) u_mcb_checker (
  .clk(clk), .rst(rst), .inj_valid(inj_valid), .inj_status(inj_status),
  .res_valid(res_valid), .res_code(res_code),
  .mce_irq(mce_irq), .reset_req(reset_req)
);

// File: tb/tb_mcbank_logger.sv
module tb_mcbank_logger;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 5;
  localparam int DW = 64;
  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] VAL = 64'h8000_0000_0000_0000;
  localparam logic [63:0] OVR = 64'h4000_0000_0000_0000;
  localparam logic [63:0] UC  = 64'h2000_0000_0000_0000;
  localparam logic [63:0] AR  = 64'h0080_0000_0000_0000;

  logic clk = 0, rst = 1, mce_en = 0;
  logic inj_valid = 0, inj_uncond = 0;
  logic [7:0] inj_bank = 0, wr_bank = 0, rd_bank = 0;
  logic [DW-1:0] inj_status = 0, inj_gstatus = 0, inj_addr = 0, inj_misc = 0, wr_data = 0;
  logic wr_en = 0;
  logic [2:0] wr_sel = 0, rd_sel = 0;
  logic [DW-1:0] rd_data;
  logic res_valid, mce_irq, reset_req;
  logic [1:0] res_code;

  int errors = 0, checks = 0;

  logic [63:0] m_cap = 0, m_gctl = 0, m_gst = 0;
  logic [63:0] m_ctl [NB];
  logic [63:0] m_st  [NB];
  logic [63:0] m_ad  [NB];
  logic [63:0] m_mi  [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  mcbank_logger #(.NUM_BANKS(NB), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .mce_en(mce_en), .inj_valid(inj_valid),
    .inj_bank(inj_bank), .inj_status(inj_status), .inj_gstatus(inj_gstatus),
    .inj_addr(inj_addr), .inj_misc(inj_misc), .inj_uncond(inj_uncond),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_bank(wr_bank), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_bank(rd_bank), .rd_data(rd_data),
    .res_valid(res_valid), .res_code(res_code),
    .mce_irq(mce_irq), .reset_req(reset_req)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic [2:0] sel, input logic [7:0] bank, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_bank = bank; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (sel)
      3'd0: m_cap = d;
      3'd1: m_gctl = d;
      3'd2: m_gst = d;
      default: if (bank < NB) begin
        if (sel == 3'd3) m_ctl[bank] = d;
        if (sel == 3'd4) m_st[bank] = d;
        if (sel == 3'd5) m_ad[bank] = d;
        if (sel == 3'd6) m_mi[bank] = d;
      end
    endcase
  endtask

  task automatic rd_check(input string tag, input logic [2:0] sel, input logic [7:0] bank);
    logic [63:0] e;
    case (sel)
      3'd0: e = m_cap;
      3'd1: e = m_gctl;
      3'd2: e = m_gst;
      default: begin
        e = 0;
        if (bank < NB) begin
          if (sel == 3'd3) e = m_ctl[bank];
          if (sel == 3'd4) e = m_st[bank];
          if (sel == 3'd5) e = m_ad[bank];
          if (sel == 3'd6) e = m_mi[bank];
        end
      end
    endcase
    @(negedge clk);
    rd_sel = sel; rd_bank = bank;
    @(negedge clk);
    check(tag, rd_data, e);
  endtask

  // Model of the requirements: returns the expected code and pulses.
  task automatic model(input logic [7:0] b, input logic [63:0] st, input logic [63:0] gs,
                       input logic [63:0] ad, input logic [63:0] mi, input logic un,
                       output logic [1:0] code, output logic irq, output logic rq,
                       output string tag);
    logic [63:0] ns, old;
    irq = 0; rq = 0;
    if (m_cap == 0 || b >= m_cap[7:0] || b >= NB || !st[63]) begin
      code = 1; tag = "R1"; return;
    end
    old = m_st[b];
    ns = st | (old[63] ? OVR : 64'd0);
    if (!un && !st[55] && m_gst[2]) begin code = 2; tag = "R2"; return; end
    if (st[61]) begin
      if (m_cap[8] && m_gctl != ONES) begin code = 2; tag = "R3"; return; end
      if (m_ctl[b] != ONES) begin code = 2; tag = "R4"; return; end
      if (!mce_en || m_gst[2]) begin code = 3; rq = 1; tag = "R5"; return; end
      code = 0; irq = 1; tag = "R6";
      m_st[b] = ns; m_ad[b] = ad; m_mi[b] = mi; m_gst = gs;
    end else if (!old[63] || !old[61]) begin
      code = 0; tag = "R7";
      m_st[b] = ns; m_ad[b] = ad; m_mi[b] = mi;
    end else begin
      code = 0; tag = "R8";
      m_st[b] = old | OVR;
    end
  endtask

  task automatic inject(input logic [7:0] b, input logic [63:0] st, input logic [63:0] gs,
                        input logic [63:0] ad, input logic [63:0] mi, input logic un);
    logic [1:0] ec; logic ei, er; string tag;
    model(b, st, gs, ad, mi, un, ec, ei, er, tag);
    @(negedge clk);
    inj_valid = 1; inj_bank = b; inj_status = st; inj_gstatus = gs;
    inj_addr = ad; inj_misc = mi; inj_uncond = un;
    @(negedge clk);
    inj_valid = 0;
    check({tag, " R9 valid"}, {63'd0, res_valid}, 64'd1);
    check({tag, " code"}, {62'd0, res_code}, {62'd0, ec});
    check({tag, " irq"}, {63'd0, mce_irq}, {63'd0, ei});
    check({tag, " reset_req"}, {63'd0, reset_req}, {63'd0, er});
    @(negedge clk);
    check("R9 single-cycle valid", {63'd0, res_valid}, 64'd0);
    if (b < NB) begin
      rd_check({tag, " bank status"}, 3'd4, b);
      rd_check({tag, " bank addr"}, 3'd5, b);
    end
    rd_check({tag, " global status"}, 3'd2, 8'd0);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < NB; i++) begin m_ctl[i] = 0; m_st[i] = 0; m_ad[i] = 0; m_mi[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    check("R10 res_valid after reset", {63'd0, res_valid}, 64'd0);
    rd_check("R10 cap reset", 3'd0, 8'd0);
    rd_check("R10 bank status reset", 3'd4, 8'd0);
    rd_check("R10 bank ctl reset", 3'd3, 8'd3);
    // R1 capability zero
    inject(8'd0, VAL, 0, 64'h11, 64'h12, 0);
    // R11 write port
    sw_write(3'd0, 8'd0, 64'h108);
    sw_write(3'd1, 8'd0, ONES);
    for (int i = 0; i < NB; i++) sw_write(3'd3, 8'(i), ONES);
    rd_check("R11 cap write", 3'd0, 8'd0);
    rd_check("R11 bank ctl write", 3'd3, 8'd4);
    rd_check("R10 out-of-range bank reads zero", 3'd3, 8'd6);
    mce_en = 1;
    // R1 range cases
    inject(8'd6, VAL, 0, 1, 2, 0);
    inject(8'd9, VAL, 0, 1, 2, 0);
    inject(8'd0, 64'h0000_0000_0000_00aa, 0, 1, 2, 0);
    // R7 corrected fresh then overflow
    inject(8'd0, VAL | 64'h17, 0, 64'h1000, 64'h5, 0);
    inject(8'd0, VAL | 64'h18, 0, 64'h2000, 64'h6, 0);
    // R6 uncorrected, sets in-progress
    inject(8'd1, VAL | UC | AR | 64'h3, 64'h5, 64'h3000, 64'h7, 0);
    // R2 ignore then unconditional
    inject(8'd2, VAL | 64'h9, 0, 64'h4000, 64'h8, 0);
    inject(8'd2, VAL | 64'h9, 0, 64'h4000, 64'h8, 1);
    // R5 recursion escalates
    inject(8'd3, VAL | UC | AR, 0, 64'h5000, 0, 0);
    sw_write(3'd2, 8'd0, 64'h0);
    mce_en = 0;
    inject(8'd3, VAL | UC | AR, 0, 64'h5000, 0, 0);
    mce_en = 1;
    // R3 global mask
    sw_write(3'd1, 8'd0, 64'hffff);
    inject(8'd3, VAL | UC | AR, 0, 64'h6000, 0, 0);
    sw_write(3'd0, 8'd0, 64'h008);
    inject(8'd3, VAL | UC | AR, 0, 64'h6100, 0, 0);
    sw_write(3'd0, 8'd0, 64'h108);
    sw_write(3'd1, 8'd0, ONES);
    // R4 bank mask
    sw_write(3'd3, 8'd4, 64'h0);
    inject(8'd4, VAL | UC | AR, 0, 64'h7000, 0, 0);
    // R8 corrected over valid uncorrected
    inject(8'd3, VAL | 64'h44, 0, 64'h8000, 64'h9, 1);
    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [63:0] st, gs;
      int r;
      r = $urandom % 16;
      if (r == 0) begin
        int c = $urandom % 5;
        sw_write(3'd0, 8'd0, c == 0 ? 64'h0 : c == 1 ? 64'h105 : c == 2 ? 64'h008 : c == 3 ? 64'h103 : 64'h108);
      end else if (r == 1) sw_write(3'd1, 8'd0, ($urandom % 3 == 0) ? r64() : ONES);
      else if (r == 2) sw_write(3'd3, 8'($urandom % NB), ($urandom % 3 == 0) ? 64'h0 : ONES);
      else if (r == 3) sw_write(3'd2, 8'd0, ($urandom % 2) ? 64'h4 : 64'h0);
      else if (r == 4) mce_en = ($urandom % 4) != 0;
      st = r64() & ~(VAL | OVR | UC | AR);
      if ($urandom % 8 != 0) st = st | VAL;
      if ($urandom % 2) st = st | UC;
      if ($urandom % 2) st = st | AR;
      gs = r64() & 64'h7;
      inject(8'($urandom % 9), st, gs, r64(), r64(), ($urandom % 4) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule